// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block owns the parity line of a 32-bit multiplexed address/data bus whose agent can act as initiator (master) or as addressed target. Each clock it looks at the address/data word, the command/byte-enable nibble, the agent's current role and the current phase type. From these it decides whether it must drive the parity line or check it.

When it generates parity, it drives the parity bit and an output enable one clock after the word that bit covers. When it checks, it computes the expected parity from the word and compares it with the parity line sampled on the next clock. A mismatch in a completed data phase gives a single-clock error strobe, meant for an active-low open-drain pad, and only while the error-response enable bit of the command register is set. A mismatch on an address phase instead sets a sticky status flag.

Top module: `pci_par_unit`

## Requirements
- R1: Parity is even: whenever `par_oe_o` is high, `par_o` together with the 32 data bits and 4 command bits of the previous clock has an even number of ones.
- R2: `par_oe_o` is high, and `par_o` valid, in the clock after a generate clock. A generate clock is one of these: role master (`role_i`=1) with phase address (`phase_i`=1) or write data (`phase_i`=3), or role target (`role_i`=2) with phase read data (`phase_i`=2). Other encodings are role idle (0, 3) and phase none (0).
- R3: `par_oe_o` is low in every clock not following a generate clock, and low while `rst_ni` is low.
- R4: A data phase is checked when it completes, that is on a clock with both `irdy_i` and `trdy_i` high, and the combination is master with read data or target with write data. If the even parity of that clock's word disagrees with `par_i` on the next clock, `perr_drive_o` is high for exactly one clock, two clocks after the completing clock.
- R5: Data-phase clocks where `irdy_i` and `trdy_i` are not both high never cause `perr_drive_o`, whatever `par_i` is.
- R6: `perr_drive_o` stays low when `cmd_i[6]` is low on the clock that `par_i` is sampled.
- R7: A parity mismatch on a target address phase sets `addr_perr_o` two clocks after the address clock. The flag stays set until reset and never causes `perr_drive_o`.
- R8: While `rst_ni` is low, all outputs are low and the sticky flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ad_i | input | 32 | Address/data word on the bus |
| cbe_i | input | 4 | Command/byte-enable nibble |
| role_i | input | 2 | 0 idle, 1 master, 2 target, 3 idle |
| phase_i | input | 2 | 0 none, 1 address, 2 read data, 3 write data |
| irdy_i | input | 1 | Initiator ready, active high |
| trdy_i | input | 1 | Target ready, active high |
| par_i | input | 1 | Sampled parity line |
| cmd_i | input | 16 | Command register; bit 6 enables data parity error reporting |
| par_o | output | 1 | Generated parity bit |
| par_oe_o | output | 1 | Output enable for the parity pad |
| perr_drive_o | output | 1 | Pull-low enable for the open-drain parity error pad |
| addr_perr_o | output | 1 | Sticky address-phase parity error flag |

## Verification
A wrong role/phase decode shows one clock later as a parity enable in the wrong clock, or as an error strobe on a phase the block owns. A lost or extra pending-check register moves the error strobe away from the second clock after completion, or repeats it. Either way the fault is visible within three clocks of the stimulus. A sticky flag that was not cleared, or one that set wrongly, stays visible at `addr_perr_o` for the rest of the run. Random stimulus mixes roles, phases, wait states, enable states and corrupted parity, and is checked every clock. Directed sequences cover the address-error, wait-state and disabled-report cases.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;
  typedef enum logic [1:0] {ROLE_IDLE = 2'd0, ROLE_MST = 2'd1, ROLE_TGT = 2'd2, ROLE_RSV = 2'd3} role_e;
  typedef enum logic [1:0] {PH_NONE = 2'd0, PH_ADDR = 2'd1, PH_RD = 2'd2, PH_WR = 2'd3} phase_e;

  typedef struct packed {
    logic gen;
    logic chk_data;
    logic chk_addr;
  } par_act_t;

  function automatic par_act_t decode_act(input logic [1:0] role, input logic [1:0] phase);
    par_act_t a;
    a.gen      = ((role == ROLE_MST) && (phase == PH_ADDR || phase == PH_WR)) ||
                 ((role == ROLE_TGT) && (phase == PH_RD));
    a.chk_data = ((role == ROLE_MST) && (phase == PH_RD)) ||
                 ((role == ROLE_TGT) && (phase == PH_WR));
    a.chk_addr = (role == ROLE_TGT) && (phase == PH_ADDR);
    return a;
  endfunction
endpackage

// File: rtl/pci_par_calc.sv
module pci_par_calc #(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic [AD_W-1:0]  ad_i,
  input  logic [CBE_W-1:0] cbe_i,
  output logic             even_par_o
);
  localparam int LANES = AD_W / 8;
  logic [LANES-1:0] lane_par;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_par[g] = ^ad_i[8*g +: 8];
  end

  // even parity: bit makes total ones even
  assign even_par_o = (^lane_par) ^ (^cbe_i);
endmodule

// File: rtl/pci_par_gen.sv
module pci_par_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gen_i,
  input  logic calc_i,
  output logic par_o,
  output logic par_oe_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      par_o    <= 1'b0;
      par_oe_o <= 1'b0;
    end else begin
      par_oe_o <= gen_i;
      par_o    <= gen_i ? calc_i : 1'b0;
    end
  end

  // R3
  oe_in_reset_chk: assert property (@(posedge clk_i) !rst_ni |-> !par_oe_o);
endmodule

// File: rtl/pci_par_chk.sv
module pci_par_chk (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic chk_data_i,
  input  logic chk_addr_i,
  input  logic calc_i,
  input  logic par_i,
  input  logic en_i,
  output logic perr_o,
  output logic addr_err_o
);
  logic pend_data_q, pend_addr_q, exp_par_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_data_q <= 1'b0;
      pend_addr_q <= 1'b0;
      exp_par_q   <= 1'b0;
      perr_o      <= 1'b0;
      addr_err_o  <= 1'b0;
    end else begin
      pend_data_q <= chk_data_i;
      pend_addr_q <= chk_addr_i;
      exp_par_q   <= calc_i;
      // compare against line one clock after the covered word
      perr_o      <= pend_data_q && (exp_par_q != par_i) && en_i;
      if (pend_addr_q && (exp_par_q != par_i)) addr_err_o <= 1'b1;
    end
  end

  // R6
  perr_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perr_o |-> $past(en_i));
  // R7
  addr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_err_o |=> addr_err_o);
endmodule

// File: rtl/pci_par_unit.sv
module pci_par_unit
  import pci_par_pkg::*;
#(
  parameter int AD_W        = 32,
  parameter int CBE_W       = 4,
  parameter int CMD_W       = 16,
  parameter int PERR_EN_BIT = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AD_W-1:0]  ad_i,
  input  logic [CBE_W-1:0] cbe_i,
  input  logic [1:0]       role_i,
  input  logic [1:0]       phase_i,
  input  logic             irdy_i,
  input  logic             trdy_i,
  input  logic             par_i,
  input  logic [CMD_W-1:0] cmd_i,
  output logic             par_o,
  output logic             par_oe_o,
  output logic             perr_drive_o,
  output logic             addr_perr_o
);
  par_act_t act;
  logic     calc;
  logic     xfer_done;

  assign act       = decode_act(role_i, phase_i);
  assign xfer_done = irdy_i && trdy_i;

  pci_par_calc #(.AD_W(AD_W), .CBE_W(CBE_W)) u_calc (
    .ad_i       (ad_i),
    .cbe_i      (cbe_i),
    .even_par_o (calc)
  );

  pci_par_gen u_gen (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .gen_i    (act.gen),
    .calc_i   (calc),
    .par_o    (par_o),
    .par_oe_o (par_oe_o)
  );

  pci_par_chk u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .chk_data_i (act.chk_data && xfer_done),
    .chk_addr_i (act.chk_addr),
    .calc_i     (calc),
    .par_i      (par_i),
    .en_i       (cmd_i[PERR_EN_BIT]),
    .perr_o     (perr_drive_o),
    .addr_err_o (addr_perr_o)
  );

  // R1
  even_par_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_oe_o |-> (^{par_o, $past(ad_i), $past(cbe_i)}) == 1'b0);
  // R4
  perr_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perr_drive_o |-> $past(irdy_i && trdy_i, 2));
  // R2
  oe_not_on_check_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_oe_o |-> !$past(act.chk_data || act.chk_addr));
endmodule

// File: tb/sim_pci_par_unit.sv
module sim_pci_par_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] ad_i = '0;
  logic [3:0]  cbe_i = '0;
  logic [1:0]  role_i = '0, phase_i = '0;
  logic        irdy_i = 1'b0, trdy_i = 1'b0, par_i = 1'b0;
  logic [15:0] cmd_i = '0;
  logic        par_o, par_oe_o, perr_drive_o, addr_perr_o;

  int n_chk = 0, n_fail = 0;

  // history: h1 = inputs of previous clock, h2 = two clocks back
  logic [35:0] h1_w, h2_w;
  logic [1:0]  h1_r, h1_p, h2_r, h2_p;
  logic        h1_done, h2_done, h1_par, h1_en;
  logic        exp_sticky;

  always #4 clk_i = ~clk_i;

  pci_par_unit u0 (.*);

  function automatic logic epar(input logic [35:0] w);
    return ^w;
  endfunction
  function automatic logic is_gen(input logic [1:0] r, input logic [1:0] p);
    return (r == 2'd1 && (p == 2'd1 || p == 2'd3)) || (r == 2'd2 && p == 2'd2);
  endfunction
  function automatic logic is_dchk(input logic [1:0] r, input logic [1:0] p);
    return (r == 2'd1 && p == 2'd2) || (r == 2'd2 && p == 2'd3);
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic clear_hist();
    h1_w = '0; h2_w = '0; h1_r = '0; h1_p = '0; h2_r = '0; h2_p = '0;
    h1_done = 0; h2_done = 0; h1_par = 0; h1_en = 0; exp_sticky = 0;
  endtask

  // called at negedge: check outputs, then drive next inputs
  task automatic step(input logic [31:0] ad, input logic [3:0] cbe, input logic [1:0] r,
                      input logic [1:0] p, input logic iy, input logic ty,
                      input logic bad, input logic en);
    logic exp_perr;
    check("R2/R3 par_oe", par_oe_o, is_gen(h1_r, h1_p));
    if (is_gen(h1_r, h1_p)) check("R1 par_o", par_o, epar(h1_w));
    exp_perr = is_dchk(h2_r, h2_p) && h2_done && (epar(h2_w) != h1_par) && h1_en;
    check("R4/R5/R6 perr_drive", perr_drive_o, exp_perr);
    if (h2_r == 2'd2 && h2_p == 2'd1 && epar(h2_w) != h1_par) exp_sticky = 1'b1;
    check("R7 addr_perr", addr_perr_o, exp_sticky);
    // par_i covers previous clock's word
    ad_i = ad; cbe_i = cbe; role_i = r; phase_i = p; irdy_i = iy; trdy_i = ty;
    par_i = epar(h1_w) ^ bad; cmd_i = {9'h0, en, 6'h0};
    h2_w = h1_w; h2_r = h1_r; h2_p = h1_p; h2_done = h1_done;
    h1_w = {ad, cbe}; h1_r = r; h1_p = p; h1_done = iy && ty;
    h1_par = par_i; h1_en = en;
    @(negedge clk_i);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    role_i = '0; phase_i = '0; irdy_i = 0; trdy_i = 0;
    #1;
    check("R8 par_oe", par_oe_o, 1'b0);
    check("R8 par_o", par_o, 1'b0);
    check("R8 perr", perr_drive_o, 1'b0);
    check("R8 addr_perr", addr_perr_o, 1'b0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    clear_hist();
    @(negedge clk_i);
  endtask

  initial begin : watchdog
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    clear_hist();
    @(negedge clk_i);
    do_reset();
    // R2 master address then write data, generate
    step(32'hDEAD_BEEF, 4'h7, 2'd1, 2'd1, 0, 0, 0, 1);
    step(32'h0000_0001, 4'h0, 2'd1, 2'd3, 1, 1, 0, 1);
    // R4 master read, completed, bad parity
    step(32'h1234_5678, 4'hF, 2'd1, 2'd2, 1, 1, 0, 1);
    step(32'h0, 4'h0, 2'd0, 2'd0, 0, 0, 1, 1);
    step(32'h0, 4'h0, 2'd0, 2'd0, 0, 0, 0, 1);
    step(32'h0, 4'h0, 2'd0, 2'd0, 0, 0, 0, 1);
    // R5 target write wait state, bad parity: no strobe
    step(32'hFFFF_0000, 4'h3, 2'd2, 2'd3, 1, 0, 0, 1);
    step(32'hFFFF_0000, 4'h3, 2'd2, 2'd3, 0, 1, 1, 1);
    step(32'h0, 4'h0, 2'd0, 2'd0, 0, 0, 1, 1);
    step(32'h0, 4'h0, 2'd0, 2'd0, 0, 0, 0, 1);
    // R6 target write completed, bad parity, enable low
    step(32'hA5A5_A5A5, 4'h1, 2'd2, 2'd3, 1, 1, 0, 0);
    step(32'h0, 4'h0, 2'd0, 2'd0, 0, 0, 1, 0);
    step(32'h0, 4'h0, 2'd0, 2'd0, 0, 0, 0, 0);
    // R7 target address bad parity: sticky, no perr
    step(32'h8000_0000, 4'hA, 2'd2, 2'd1, 1, 1, 0, 1);
    step(32'h0, 4'h0, 2'd0, 2'd0, 0, 0, 1, 1);
    repeat (4) step(32'h0, 4'h0, 2'd0, 2'd0, 0, 0, 0, 1);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      step($urandom, 4'($urandom), 2'($urandom), 2'($urandom),
           1'($urandom), 1'($urandom), ($urandom % 4) == 0, ($urandom % 5) != 0);
      if (i == 1500) do_reset();
    end
    repeat (3) step(32'h0, 4'h0, 2'd0, 2'd0, 0, 0, 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule